// File: doc/BRIEF.md
# Two-Phase Transition-Signalled Pipeline FIFO

This block is a chain of identical stages that move words from an upstream producer to a downstream consumer using two-phase handshakes. A request or acknowledge wire signals an event by changing level; a rising edge and a falling edge mean the same thing, so no wire ever has to return to zero between transfers. Each stage pairs a control bit that behaves like a Muller C-element with a word register. The register loads whenever the control bit changes, in either direction.

The model is synchronous. A system clock samples every handshake level, and a level that differs from its partner counts as a pending event. A stage fires when a new request is pending on its input and its own previous output request has already been acknowledged. Firing does three things in the same cycle: it acknowledges the stage before it, captures that stage's word, and arms a bundling counter. The request towards the next stage changes only after that counter has run out. The consumer must hold acknowledge events until it has a request, and the producer must hold its word steady until its request has been acknowledged.

Top module: `tpf_fifo`

## Requirements
- R1: A synchronous active-low reset drives `up_ack`, `dn_req` and `dn_data` to 0 and leaves every stage empty.
- R2: Both the rising and the falling edge of `up_req` hand over a word. Both the rising and the falling edge of `dn_req` announce a word.
- R3: When the first stage is empty, `up_ack` changes exactly one clock edge after the edge that samples a changed `up_req`.
- R4: `up_ack` never changes unless `up_req` differs from `up_ack`. A request is not acknowledged while the FIFO is full.
- R5: A word entering an empty FIFO makes `dn_req` change exactly STAGES*(BUNDLE+1)-1 edges after the edge that changed `up_ack`. A stage's outgoing request only ever moves to match its control bit, and a stage fires only after its previous request has been issued.
- R6: While `dn_req` differs from `dn_ack`, `dn_data` stays constant. A stage register changes only in a cycle in which that stage fires.
- R7: With `dn_ack` frozen, the FIFO accepts exactly STAGES words, one per stage, and then withholds `up_ack`.
- R8: Words leave in the order they were accepted, with none lost and none repeated, under any timing of upstream and downstream events.
- R9: From a full FIFO with one request waiting upstream, a single `dn_ack` change causes `up_ack` to change exactly STAGES clock edges later, counting from the first edge that samples the new `dn_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all handshake levels |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Upstream request; each level change offers `up_data` |
| up_data | input | WIDTH | Upstream word, held stable until acknowledged |
| up_ack | output | 1 | Upstream acknowledge; each change accepts one word |
| dn_req | output | 1 | Downstream request; each change presents `dn_data` |
| dn_data | output | WIDTH | Word held by the last stage |
| dn_ack | input | 1 | Downstream acknowledge; each change consumes one word |

## Verification
The hardest situation to reach is a completely full pipeline, with every stage holding a word and a further request waiting. From there the freeing of one slot has to travel backward one stage per clock until the producer is acknowledged. The stimulus gets there by freezing the downstream acknowledge, offering words until one goes unanswered for longer than any fill could take, and then releasing exactly one acknowledge event while it counts edges. Randomised gaps on both sides then mix partial fills, bubbles and back-to-back transfers, and a reference queue checks every word as it leaves.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

  // A two-phase channel has an outstanding event when its two levels differ.
  function automatic logic evt_pending(input logic req, input logic ack);
    return req ^ ack;
  endfunction

  // Edges from a stage-0 firing to the last stage's request change, empty pipe.
  function automatic int unsigned fill_latency(input int unsigned stages,
                                               input int unsigned bundle);
    return stages * (bundle + 1) - 1;
  endfunction

  // Clamp the bundling delay to its legal minimum.
  function automatic int unsigned bundle_eff(input int unsigned bundle);
    return (bundle < 1) ? 1 : bundle;
  endfunction

endpackage

// File: rtl/tpf_ctrl.sv
module tpf_ctrl
  import tpf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,   // request level arriving from the previous stage
  input  logic ack_in,   // acknowledge level returned by the next stage
  output logic ctl,      // C-element output level
  output logic ctl_nxt,  // value ctl takes at the coming edge
  output logic fire      // ctl changes at the coming edge
);

  logic new_req;
  logic out_done;

  // A fresh request is waiting, and our previous output event was answered.
  assign new_req  = evt_pending(req_in, ctl);
  assign out_done = !evt_pending(ack_in, ctl);
  assign fire     = new_req && out_done;
  assign ctl_nxt  = ctl ^ fire;

  always_ff @(posedge clk) begin
    if (!rst_n) ctl <= 1'b0;
    else        ctl <= ctl_nxt;
  end

endmodule

// File: rtl/tpf_bundle.sv
module tpf_bundle
  import tpf_pkg::*;
#(
  parameter int unsigned BUNDLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,     // stage fires at this edge
  input  logic ctl,      // control level after firing
  output logic req_out   // delayed request towards the next stage
);

  localparam int unsigned DLY = bundle_eff(BUNDLE);
  localparam int unsigned CW  = $clog2(DLY + 1);

  logic [CW-1:0] cnt;

  // The counter loads on firing; the request follows ctl on its last count.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      req_out <= 1'b0;
    end else if (fire) begin
      cnt <= CW'(DLY);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) req_out <= ctl;
    end
  end

endmodule

// File: rtl/tpf_dreg.sv
module tpf_dreg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl,      // present control level
  input  logic             ctl_nxt,  // control level after this edge
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic edge_any;

  // Loads on a rising or a falling control change alike.
  assign edge_any = ctl ^ ctl_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (edge_any) q <= d;
  end

endmodule

// File: rtl/tpf_fifo.sv
module tpf_fifo
  import tpf_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 4,
  parameter int unsigned BUNDLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_req,
  input  logic [WIDTH-1:0] up_data,
  output logic             up_ack,
  output logic             dn_req,
  output logic [WIDTH-1:0] dn_data,
  input  logic             dn_ack
);

  localparam int unsigned LAST = STAGES - 1;
  localparam int unsigned FLAT = STAGES * WIDTH;

  // Named per-stage events, visible to the bound checker.
  logic [STAGES-1:0] st_ctl;
  logic [STAGES-1:0] st_nxt;
  logic [STAGES-1:0] st_fire;
  logic [STAGES-1:0] st_rout;
  logic [STAGES-1:0] st_rin;
  logic [STAGES-1:0] st_ain;
  logic [WIDTH-1:0]  st_q   [STAGES];
  logic [WIDTH-1:0]  st_d   [STAGES];
  logic [FLAT-1:0]   st_flat;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign st_rin[i] = up_req;
      assign st_d[i]   = up_data;
    end else begin : g_mid
      assign st_rin[i] = st_rout[i-1];
      assign st_d[i]   = st_q[i-1];
    end

    if (i == LAST) begin : g_tail
      assign st_ain[i] = dn_ack;
    end else begin : g_link
      assign st_ain[i] = st_ctl[i+1];
    end

    tpf_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_in  (st_rin[i]),
      .ack_in  (st_ain[i]),
      .ctl     (st_ctl[i]),
      .ctl_nxt (st_nxt[i]),
      .fire    (st_fire[i])
    );

    tpf_bundle #(.BUNDLE(BUNDLE)) u_bundle (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (st_fire[i]),
      .ctl     (st_nxt[i]),
      .req_out (st_rout[i])
    );

    tpf_dreg #(.WIDTH(WIDTH)) u_dreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (st_ctl[i]),
      .ctl_nxt (st_nxt[i]),
      .d       (st_d[i]),
      .q       (st_q[i])
    );

    assign st_flat[i*WIDTH +: WIDTH] = st_q[i];
  end

  assign up_ack  = st_ctl[0];
  assign dn_req  = st_rout[LAST];
  assign dn_data = st_q[LAST];

endmodule

// File: rtl/tpf_fifo_chk.sv
module tpf_fifo_chk #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    up_req,
  input logic                    up_ack,
  input logic                    dn_req,
  input logic                    dn_ack,
  input logic [WIDTH-1:0]        dn_data,
  input logic [STAGES-1:0]       st_ctl,
  input logic [STAGES-1:0]       st_rout,
  input logic [STAGES-1:0]       st_fire,
  input logic [STAGES*WIDTH-1:0] st_flat
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (up_ack == 1'b0 && dn_req == 1'b0 && dn_data == '0)); // R1

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ack != $past(up_ack)) |-> ($past(up_req) != $past(up_ack))); // R4

  AST_DN_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dn_req != dn_ack) && dn_req == $past(dn_req) && dn_req != dn_ack)
      |-> $stable(dn_data)); // R6

  for (genvar i = 0; i < STAGES; i++) begin : g_chk
    AST_FIRE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      st_fire[i] |-> (st_rout[i] == st_ctl[i])); // R5

    AST_ROUT_TRACKS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rout[i] != $past(st_rout[i])) |-> (st_rout[i] == st_ctl[i])); // R5

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !st_fire[i] |=> $stable(st_flat[i*WIDTH +: WIDTH])); // R6
  end

endmodule

bind tpf_fifo tpf_fifo_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .up_req  (up_req),
  .up_ack  (up_ack),
  .dn_req  (dn_req),
  .dn_ack  (dn_ack),
  .dn_data (dn_data),
  .st_ctl  (st_ctl),
  .st_rout (st_rout),
  .st_fire (st_fire),
  .st_flat (st_flat)
);

// File: tb/sim_tpf_fifo.sv
module sim_tpf_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int S   = 4;
  localparam int B   = 2;
  localparam int NRAND = 300;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_req = 1'b0;
  logic [W-1:0] up_data = '0;
  logic         up_ack;
  logic         dn_req;
  logic [W-1:0] dn_data;
  logic         dn_ack = 1'b0;

  tpf_fifo #(.WIDTH(W), .STAGES(S), .BUNDLE(B)) u0 (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_data(up_data),
    .up_ack(up_ack), .dn_req(dn_req), .dn_data(dn_data), .dn_ack(dn_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_err = 0;
  logic [W-1:0] model_q[$];
  bit mon_en = 1'b0;
  logic p_up_ack = 1'b0, p_dn_req = 1'b0, p_dn_ack = 1'b0;
  logic [W-1:0] held_dn = '0;
  int n_in = 0, n_out = 0, n_acked = 0;
  int in_rise = 0, in_fall = 0, out_rise = 0, out_fall = 0;
  bit prod_done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference monitor: samples on the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (mon_en) begin
      if (up_ack != p_up_ack) begin
        chk(up_req != p_up_ack, "R4", "ack without pending request", int'(up_ack), int'(p_up_ack));
        model_q.push_back(up_data);
        n_in++;
        if (up_ack) in_rise++; else in_fall++;
      end
      if (dn_req != p_dn_req) begin
        chk(model_q.size() > 0, "R8", "word delivered from empty model", model_q.size(), 1);
        if (model_q.size() > 0) begin
          chk(dn_data == model_q[0], "R8", "output word order", int'(dn_data), int'(model_q[0]));
          void'(model_q.pop_front());
        end
        held_dn = dn_data;
        n_out++;
        if (dn_req) out_rise++; else out_fall++;
      end else if (dn_req != dn_ack) begin
        chk(dn_data == held_dn, "R6", "dn_data changed while pending", int'(dn_data), int'(held_dn));
      end
      if (dn_ack != p_dn_ack) n_acked++;
      chk((n_in - n_acked) <= S, "R7", "occupancy above stage count", n_in - n_acked, S);
    end
    p_up_ack = up_ack;
    p_dn_req = dn_req;
    p_dn_ack = dn_ack;
  end

  task automatic offer(input logic [W-1:0] v);
    @(negedge clk); #1;
    up_data = v;
    up_req  = ~up_req;
  endtask

  task automatic send_word(input logic [W-1:0] v);
    int guard;
    offer(v);
    guard = 0;
    while (up_ack != up_req && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(up_ack == 1'b0, "R1", "up_ack after reset", int'(up_ack), 0);
    chk(dn_req == 1'b0, "R1", "dn_req after reset", int'(dn_req), 0);
    chk(dn_data == '0, "R1", "dn_data after reset", int'(dn_data), 0);
    mon_en = 1'b1;

    // R3 and R5: single word through an empty FIFO
    offer(8'hA5);
    @(negedge clk);
    chk(up_ack == up_req, "R3", "ack one edge after request", int'(up_ack), int'(up_req));
    c = 0;
    while (dn_req == 1'b0 && c < 1000) begin
      @(negedge clk);
      c++;
    end
    chk(c == S*(B+1)-1, "R5", "fill latency in edges", c, S*(B+1)-1);
    @(negedge clk); #1 dn_ack = ~dn_ack;
    repeat (3) @(negedge clk);

    // R4: no request, no acknowledge
    repeat (20) @(negedge clk);
    chk(up_ack == up_req, "R4", "idle ack stays put", int'(up_ack), int'(up_req));

    // R7: fill with dn_ack frozen
    for (int k = 0; k < S; k++) send_word(8'h10 + 8'(k));
    chk(up_ack == up_req, "R7", "all stages accept a word", int'(up_ack), int'(up_req));
    offer(8'h55);
    repeat (3*S*(B+1) + 4) @(negedge clk);
    chk(up_ack != up_req, "R7", "extra word refused when full", int'(up_ack), int'(~up_req));
    chk(n_in - n_acked == S, "R7", "words held when full", n_in - n_acked, S);

    // R9: one downstream event frees one slot, bubble walks back
    #1 dn_ack = ~dn_ack;
    c = 0;
    while (up_ack != up_req && c < 1000) begin
      @(negedge clk);
      c++;
    end
    chk(c == S, "R9", "bubble return edges", c, S);

    // drain in order (R8 via monitor)
    c = 0;
    while ((model_q.size() > 0 || dn_req != dn_ack) && c < 5000) begin
      @(negedge clk); #1;
      if (dn_req != dn_ack) dn_ack = ~dn_ack;
      c++;
    end
    @(negedge clk);
    chk(model_q.size() == 0, "R8", "directed drain complete", model_q.size(), 0);

    // Random timing on both ends (R2, R8)
    fork
      begin
        for (int k = 0; k < NRAND; k++) begin
          repeat ($urandom_range(0, 3)) @(negedge clk);
          send_word(8'($urandom_range(0, 255)));
        end
        prod_done = 1'b1;
      end
      begin
        int g;
        g = 0;
        while (!(prod_done && model_q.size() == 0 && dn_req == dn_ack) && g < 100000) begin
          @(negedge clk); #1;
          if (dn_req != dn_ack && $urandom_range(0, 2) == 0) dn_ack = ~dn_ack;
          g++;
        end
      end
    join
    repeat (4) @(negedge clk);
    chk(n_out == n_in, "R8", "words out equal words in", n_out, n_in);
    chk(model_q.size() == 0, "R8", "nothing left in model", model_q.size(), 0);
    chk(in_rise > 0 && in_fall > 0, "R2", "accepted on both request edges", in_fall, in_rise);
    chk(out_rise > 0 && out_fall > 0, "R2", "delivered on both request edges", out_fall, out_rise);
    summary();
    $finish;
  end

endmodule